// File: doc/BRIEF.md
# Software Write-Protection Sequencer

This block sits between the host byte-load port and the internal write engine of a byte-wide nonvolatile array. It watches every byte load, with its address and data, and decides whether that load may reach the page buffer. A short unlock prefix of three command loads opens a page-load window. Completing that prefix also switches on a persistent software protection mode. Once the mode is on, every page write must start with the prefix.

Two longer six-load command sequences are recognised. One leaves protection mode. The other requests a full-array erase. When protection is on, a data load that does not follow the prefix is refused and starts a lockout window of a fixed, parameterised length. During that window every load is ignored. Loads that arrive while the write engine reports an active internal cycle are ignored in the same way.

Command addresses and data values are parameters, and only the low address bits take part in matching.

Top module: `swp_seq`

## Requirements
- R1: After reset, whether applied at start-up or mid-operation, `prot_on`, `lockout` and `erase_req` are 0, and protection mode is off.
- R2: With protection off and no sequence in progress, a load that is not a command step raises `wr_permit` in the same cycle as `ld_valid`.
- R3: The loads (A, 0xAA), (B, 0x55), (A, 0xA0) form the unlock prefix; the defaults are A = 0x5555 and B = 0x2AAA. None of these three loads is permitted. `prot_on` is 1 from the clock edge that takes the third load, and the loads that follow it are permitted.
- R4: While the page window is open, `eng_busy` = 1 closes it. The next load must then start with the prefix again, and no load is permitted while `eng_busy` is 1.
- R5: With protection on, a data load outside a page window is not permitted. `lockout` is then 1 for exactly LOCK_CYC cycles, starting at the edge that takes that load.
- R6: Loads during `lockout` or during `eng_busy` are not permitted. They do not advance the sequence matcher, and they do not restart the lockout window.
- R7: The loads (A, 0xAA), (B, 0x55), (A, 0x80), (A, 0xAA), (B, 0x55), (A, 0x20) clear `prot_on` at the edge that takes the sixth load.
- R8: The loads (A, 0xAA), (B, 0x55), (A, 0x80), (A, 0xAA), (B, 0x55), (A, 0x10) pulse `erase_req` high for exactly one cycle after the sixth load, and `prot_on` does not change.
- R9: A load that is not the expected next step returns the matcher to idle. That load is then handled as a plain data load: it is permitted if protection is off, and it starts a lockout if protection is on.
- R10: Only address bits [CMP_BITS-1:0] (default 15) are compared, so command addresses that differ only above that bit still match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ld_valid | input | 1 | Byte-load strobe |
| ld_addr | input | AW (17) | Load address |
| ld_data | input | DW (8) | Load data |
| eng_busy | input | 1 | Write engine internal cycle active |
| wr_permit | output | 1 | This load may enter the page buffer (combinational) |
| erase_req | output | 1 | One-cycle full-erase request |
| prot_on | output | 1 | Software protection mode active |
| lockout | output | 1 | Lockout window active; all loads ignored |

## Verification
The embedded properties check several rules on every cycle:
- no permit during lockout or an engine cycle,
- the erase request lasting a single cycle,
- the protection flag following a completed prefix or disable sequence,
- the matcher holding still when loads are refused,
- lockout starting only after a refused protected write.

Only the bench scenarios can show the following:
- the exact order of the command sequences,
- the exact lockout length,
- that the loads ignored during lockout left no partial sequence behind,
- that upper address bits are masked.

// File: rtl/swp_pkg.sv
package swp_pkg;

  // sequence matcher position
  typedef enum logic [2:0] {
    M_IDLE = 3'd0,  // nothing matched
    M_K1   = 3'd1,  // first unlock key seen
    M_K2   = 3'd2,  // second unlock key seen
    M_PAGE = 3'd3,  // page-load window open
    M_X1   = 3'd4,  // extended command byte seen
    M_X2   = 3'd5,  // extended + first key
    M_X3   = 3'd6   // extended + both keys
  } mstate_t;

  // index of each command key in the hit vector
  localparam int KEY_UNL1  = 0;
  localparam int KEY_UNL2  = 1;
  localparam int KEY_PAGE  = 2;
  localparam int KEY_EXT   = 3;
  localparam int KEY_OFF   = 4;
  localparam int KEY_ERASE = 5;
  localparam int NUM_KEYS  = 6;

endpackage

// File: rtl/swp_matcher.sv
module swp_matcher
  import swp_pkg::*;
#(
  parameter int            AW        = 17,
  parameter int            DW        = 8,
  parameter int            CMP_BITS  = 15,
  parameter logic [AW-1:0] ADDR_A    = 'h5555,
  parameter logic [AW-1:0] ADDR_B    = 'h2AAA,
  parameter logic [DW-1:0] DAT_K1    = 'hAA,
  parameter logic [DW-1:0] DAT_K2    = 'h55,
  parameter logic [DW-1:0] DAT_PAGE  = 'hA0,
  parameter logic [DW-1:0] DAT_EXT   = 'h80,
  parameter logic [DW-1:0] DAT_OFF   = 'h20,
  parameter logic [DW-1:0] DAT_ERASE = 'h10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                accept,
  input  logic                busy,
  input  logic [CMP_BITS-1:0] addr,
  input  logic [DW-1:0]       data,
  output logic                ev_open,
  output logic                ev_off,
  output logic                ev_erase,
  output logic                ev_data,
  output logic                in_page
);

  localparam logic [AW-1:0] KEY_A [NUM_KEYS] =
    '{ADDR_A, ADDR_B, ADDR_A, ADDR_A, ADDR_A, ADDR_A};
  localparam logic [DW-1:0] KEY_D [NUM_KEYS] =
    '{DAT_K1, DAT_K2, DAT_PAGE, DAT_EXT, DAT_OFF, DAT_ERASE};

  mstate_t             state_q, state_d;
  logic [NUM_KEYS-1:0] hit;

  // one comparator per command key, low address bits only
  for (genvar gi = 0; gi < NUM_KEYS; gi++) begin : g_key
    assign hit[gi] = (addr == KEY_A[gi][CMP_BITS-1:0]) && (data == KEY_D[gi]);
  end

  // next-state and event decode
  always_comb begin
    state_d  = state_q;
    ev_open  = 1'b0;
    ev_off   = 1'b0;
    ev_erase = 1'b0;
    ev_data  = 1'b0;
    if (state_q == M_PAGE) begin
      if (busy) state_d = M_IDLE;
    end else if (accept) begin
      state_d = M_IDLE;
      unique case (state_q)
        M_IDLE: begin
          if (hit[KEY_UNL1]) state_d = M_K1;
          else               ev_data = 1'b1;
        end
        M_K1: begin
          if (hit[KEY_UNL2]) state_d = M_K2;
          else               ev_data = 1'b1;
        end
        M_K2: begin
          if (hit[KEY_PAGE]) begin
            state_d = M_PAGE;
            ev_open = 1'b1;
          end else if (hit[KEY_EXT]) begin
            state_d = M_X1;
          end else begin
            ev_data = 1'b1;
          end
        end
        M_X1: begin
          if (hit[KEY_UNL1]) state_d = M_X2;
          else               ev_data = 1'b1;
        end
        M_X2: begin
          if (hit[KEY_UNL2]) state_d = M_X3;
          else               ev_data = 1'b1;
        end
        M_X3: begin
          if (hit[KEY_OFF])        ev_off   = 1'b1;
          else if (hit[KEY_ERASE]) ev_erase = 1'b1;
          else                     ev_data  = 1'b1;
        end
        default: ev_data = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= M_IDLE;
    else        state_q <= state_d;
  end

  assign in_page = (state_q == M_PAGE);

  // R3: the page window opens only from a completed prefix
  p_page_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == M_PAGE && $past(state_q) != M_PAGE) |->
      $past(accept && hit[KEY_PAGE] && state_q == M_K2));

  // R6: refused loads leave the matcher where it was
  p_hold_refused_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept && state_q != M_PAGE) |=> $stable(state_q));

  // R4: busy always closes an open page window
  p_page_close_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && state_q == M_PAGE) |=> state_q == M_IDLE);

endmodule

// File: rtl/swp_lockout.sv
module swp_lockout #(
  parameter int LOCK_CYC = 50000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic lockout
);

  localparam int CW = $clog2(LOCK_CYC + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (trig)             cnt_d = CW'(LOCK_CYC);
    else if (cnt_q != '0) cnt_d = cnt_q - CW'(1);
    else                  cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign lockout = (cnt_q != '0);

  // R5: a refused write always opens the window
  p_trig_locks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> lockout);

  // R5: the window never opens without a refused write
  p_rise_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lockout) |-> $past(trig));

endmodule

// File: rtl/swp_seq.sv
module swp_seq
  import swp_pkg::*;
#(
  parameter int            AW        = 17,
  parameter int            DW        = 8,
  parameter int            CMP_BITS  = 15,
  parameter int            LOCK_CYC  = 50000,
  parameter logic [AW-1:0] ADDR_A    = 'h5555,
  parameter logic [AW-1:0] ADDR_B    = 'h2AAA,
  parameter logic [DW-1:0] DAT_K1    = 'hAA,
  parameter logic [DW-1:0] DAT_K2    = 'h55,
  parameter logic [DW-1:0] DAT_PAGE  = 'hA0,
  parameter logic [DW-1:0] DAT_EXT   = 'h80,
  parameter logic [DW-1:0] DAT_OFF   = 'h20,
  parameter logic [DW-1:0] DAT_ERASE = 'h10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_valid,
  input  logic [AW-1:0] ld_addr,
  input  logic [DW-1:0] ld_data,
  input  logic          eng_busy,
  output logic          wr_permit,
  output logic          erase_req,
  output logic          prot_on,
  output logic          lockout
);

  // asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  // upper address bits take no part in matching
  if (AW > CMP_BITS) begin : g_hi
    logic unused_addr_hi;
    assign unused_addr_hi = ^ld_addr[AW-1:CMP_BITS];
  end

  logic accept;
  logic ev_open, ev_off, ev_erase, ev_data, in_page;
  logic lock_trig;
  logic prot_q, prot_d;
  logic erase_q, erase_d;

  assign accept = ld_valid && !eng_busy && !lockout;

  swp_matcher #(
    .AW(AW), .DW(DW), .CMP_BITS(CMP_BITS),
    .ADDR_A(ADDR_A), .ADDR_B(ADDR_B),
    .DAT_K1(DAT_K1), .DAT_K2(DAT_K2), .DAT_PAGE(DAT_PAGE),
    .DAT_EXT(DAT_EXT), .DAT_OFF(DAT_OFF), .DAT_ERASE(DAT_ERASE)
  ) u_match (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .accept   (accept),
    .busy     (eng_busy),
    .addr     (ld_addr[CMP_BITS-1:0]),
    .data     (ld_data),
    .ev_open  (ev_open),
    .ev_off   (ev_off),
    .ev_erase (ev_erase),
    .ev_data  (ev_data),
    .in_page  (in_page)
  );

  assign lock_trig = ev_data && prot_q;

  swp_lockout #(.LOCK_CYC(LOCK_CYC)) u_lock (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .trig    (lock_trig),
    .lockout (lockout)
  );

  // mode flag and erase pulse: next state
  always_comb begin
    prot_d = prot_q;
    if (ev_open)     prot_d = 1'b1;
    else if (ev_off) prot_d = 1'b0;
    erase_d = ev_erase;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      prot_q  <= 1'b0;
      erase_q <= 1'b0;
    end else begin
      prot_q  <= prot_d;
      erase_q <= erase_d;
    end
  end

  assign wr_permit = accept && (in_page || (ev_data && !prot_q));
  assign prot_on   = prot_q;
  assign erase_req = erase_q;

  // R6: nothing is permitted while locked out or while the engine runs
  p_no_permit_lock_r6: assert property (@(posedge clk) disable iff (!rst_n_s)
    (lockout || eng_busy) |-> !wr_permit);

  // R8: the erase request lasts a single cycle
  p_erase_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    erase_req |=> !erase_req);

  // R3: a completed prefix switches protection on
  p_prot_set_r3: assert property (@(posedge clk) disable iff (!rst_n_s)
    ev_open |=> prot_on);

  // R7: a completed disable sequence switches protection off
  p_prot_clr_r7: assert property (@(posedge clk) disable iff (!rst_n_s)
    ev_off |=> !prot_on);

  // R8: erase leaves the mode untouched
  p_erase_keeps_mode_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    ev_erase |=> $stable(prot_on));

endmodule

// File: tb/tb_swp_seq.sv
`timescale 1ns/1ps
module tb_swp_seq;

  localparam int AW   = 17;
  localparam int DW   = 8;
  localparam int LOCK = 8;
  localparam int NV   = 33;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ld_valid;
  logic [AW-1:0] ld_addr;
  logic [DW-1:0] ld_data;
  logic          eng_busy;
  logic          wr_permit, erase_req, prot_on, lockout;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  done    = 1'b0;

  always #2 clk = ~clk;

  swp_seq #(.AW(AW), .DW(DW), .LOCK_CYC(LOCK)) dut (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_addr(ld_addr),
    .ld_data(ld_data), .eng_busy(eng_busy), .wr_permit(wr_permit),
    .erase_req(erase_req), .prot_on(prot_on), .lockout(lockout)
  );

  // {busy, addr[16:0], data[7:0], permit, prot_after, lock_after, erase_after, req[3:0]}
  localparam logic [33:0] VEC [NV] = '{
    {1'b0, 17'h00100, 8'h12, 4'b1000, 4'd2},   // R2 plain write
    {1'b0, 17'h05555, 8'hAA, 4'b0000, 4'd9},   // R9 first key
    {1'b0, 17'h02AAA, 8'h66, 4'b1000, 4'd9},   // R9 wrong key -> data
    {1'b0, 17'h05555, 8'hA0, 4'b1000, 4'd9},   // R9 no prefix -> data
    {1'b0, 17'h05555, 8'hAA, 4'b0000, 4'd3},   // R3 prefix
    {1'b0, 17'h02AAA, 8'h55, 4'b0000, 4'd3},
    {1'b0, 17'h05555, 8'hA0, 4'b0100, 4'd3},
    {1'b0, 17'h00200, 8'h34, 4'b1100, 4'd3},   // R3 page data
    {1'b0, 17'h00201, 8'h56, 4'b1100, 4'd3},
    {1'b1, 17'h00202, 8'h78, 4'b0100, 4'd4},   // R4 busy closes
    {1'b0, 17'h05555, 8'hAA, 4'b0100, 4'd3},
    {1'b0, 17'h02AAA, 8'h55, 4'b0100, 4'd3},
    {1'b0, 17'h05555, 8'hA0, 4'b0100, 4'd3},
    {1'b0, 17'h00300, 8'h9A, 4'b1100, 4'd3},
    {1'b1, 17'h05555, 8'hAA, 4'b0100, 4'd6},   // R6 ignored in busy
    {1'b0, 17'h05555, 8'hAA, 4'b0100, 4'd8},   // R8 erase
    {1'b0, 17'h02AAA, 8'h55, 4'b0100, 4'd8},
    {1'b0, 17'h05555, 8'h80, 4'b0100, 4'd8},
    {1'b0, 17'h05555, 8'hAA, 4'b0100, 4'd8},
    {1'b0, 17'h02AAA, 8'h55, 4'b0100, 4'd8},
    {1'b0, 17'h05555, 8'h10, 4'b0101, 4'd8},
    {1'b0, 17'h05555, 8'hAA, 4'b0100, 4'd7},   // R7 disable
    {1'b0, 17'h02AAA, 8'h55, 4'b0100, 4'd7},
    {1'b0, 17'h05555, 8'h80, 4'b0100, 4'd7},
    {1'b0, 17'h05555, 8'hAA, 4'b0100, 4'd7},
    {1'b0, 17'h02AAA, 8'h55, 4'b0100, 4'd7},
    {1'b0, 17'h05555, 8'h20, 4'b0000, 4'd7},
    {1'b0, 17'h00400, 8'h11, 4'b1000, 4'd7},   // R7 writes free again
    {1'b0, 17'h15555, 8'hAA, 4'b0000, 4'd10},  // R10 upper bit ignored
    {1'b0, 17'h12AAA, 8'h55, 4'b0000, 4'd10},
    {1'b0, 17'h15555, 8'hA0, 4'b0100, 4'd10},
    {1'b0, 17'h00500, 8'h22, 4'b1100, 4'd10},
    {1'b1, 17'h00000, 8'h00, 4'b0100, 4'd4}    // R4 no permit in busy
  };

  task automatic check(input string req, input string what,
                       input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  // drive at posedge+1, check permit at +2, take the edge, return at +1
  task automatic load(input logic busy, input logic [AW-1:0] a,
                      input logic [DW-1:0] d, input logic exp_perm,
                      input string req);
    ld_valid = 1'b1; eng_busy = busy; ld_addr = a; ld_data = d;
    #1;
    check(req, "wr_permit", wr_permit, exp_perm);
    @(posedge clk); #1;
    ld_valid = 1'b0; eng_busy = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog all-requirements actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int n;
    rst_n = 1'b0; ld_valid = 1'b0; eng_busy = 1'b0; ld_addr = '0; ld_data = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R1", "prot_on", prot_on, 1'b0);
    check("R1", "lockout", lockout, 1'b0);
    check("R1", "erase_req", erase_req, 1'b0);
    check("R1", "wr_permit idle", wr_permit, 1'b0);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;

    for (int i = 0; i < NV; i++) begin
      string r;
      r = $sformatf("R%0d", VEC[i][3:0]);
      load(VEC[i][33], VEC[i][32:16], VEC[i][15:8], VEC[i][7], r);
      check(r, $sformatf("prot_on v%0d", i), prot_on, VEC[i][6]);
      check(r, $sformatf("lockout v%0d", i), lockout, VEC[i][5]);
      check(r, $sformatf("erase_req v%0d", i), erase_req, VEC[i][4]);
    end

    // R5: protected data load after the page closed -> refused, lockout
    load(1'b0, 17'h00600, 8'h33, 1'b0, "R5");
    check("R5", "lockout start", lockout, 1'b1);
    // R6: loads inside the window are ignored and do not extend it
    n = 0;
    for (int k = 0; lockout && k < 100; k++) begin
      n++;
      if (k == 0)      load(1'b0, 17'h05555, 8'hAA, 1'b0, "R6");
      else if (k == 1) load(1'b0, 17'h02AAA, 8'h55, 1'b0, "R6");
      else if (k == 2) load(1'b0, 17'h00700, 8'h44, 1'b0, "R6");
      else begin @(posedge clk); #1; end
    end
    check("R5", $sformatf("lockout length %0d", n), n == LOCK, 1'b1);
    // R6: keys sent in lockout left no partial prefix
    load(1'b0, 17'h05555, 8'hA0, 1'b0, "R6");
    check("R6", "relock after stray key", lockout, 1'b1);
    check("R6", "prot_on kept", prot_on, 1'b1);
    for (int k = 0; lockout && k < 100; k++) begin @(posedge clk); #1; end

    // R9: broken prefix under protection becomes a refused write
    load(1'b0, 17'h05555, 8'hAA, 1'b0, "R9");
    load(1'b0, 17'h05555, 8'h55, 1'b0, "R9");
    check("R9", "lockout after mismatch", lockout, 1'b1);

    // R1: reset in the middle of a lockout with protection on
    rst_n = 1'b0;
    #1;
    check("R1", "prot_on async", prot_on, 1'b0);
    check("R1", "lockout async", lockout, 1'b0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    load(1'b0, 17'h00800, 8'h5A, 1'b1, "R1");
    check("R1", "prot_on after reset write", prot_on, 1'b0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule